// File: doc/BRIEF.md
# Parallel display bus strobe timer

This block sequences the control strobes of one access on an 8080-style parallel display bus. A start request picks a write or a read; from the next clock the block counts bus ticks and drives chip-select, write-enable and read-enable. Each strobe is active for a programmed window of ticks. On a read the block also raises a one-clock capture strobe and latches the bus data at a programmed access tick. It pulses done once the cycle time for the access type has run out. A command/data line follows a per-access selector, and each of the four outputs has its own polarity control.

The timing arrives as two packed words and a granularity bit that stretches every tick to two clocks. The block checks a configuration against its ordering rules when it starts an access. A configuration that breaks any rule sets a sticky error flag, and the block then performs no access. The block latches the timing, the access type, the command selector and the granularity at start. Changes to these inputs during an access therefore have no effect on it.

Top module: `pbus_strobe_timer`

## Requirements
- R1: Tick 0 is the first clock after an accepted start, and the tick count then advances once per tick. The strobe-window fields are in `edge_word`: CS-on bits 3:0, CS-off bits 9:4, WE-on bits 13:10, WE-off bits 19:14, RE-on bits 23:20 and RE-off bits 29:24. A strobe is active while on <= tick < off. CS is active on both access types, WE only on writes (`rd_sel`=0) and RE only on reads (`rd_sel`=1).
- R2: With `tick_x2`=1 latched at start, every tick lasts two clocks, so every window position, done position and capture position doubles in clocks.
- R3: Each output pin is its active level XOR a bit of `pol_inv` (bit 0 CS, bit 1 WE, bit 2 RE, bit 3 A0). A bit value of 1 makes that pin active-low. When no access is running, each pin rests at its `pol_inv` bit.
- R4: A0 is active for the whole busy span of an access whose `cmd_sel` was 1 at start, and inactive otherwise.
- R5: The read access time is in `cyc_word` bits 27:22. On a read, `cap_o` is high for one clock on the first clock of the tick equal to the access time. `rd_data` takes `bus_din` at the clock edge that ends that clock and holds it afterwards.
- R6: The write cycle time is in `cyc_word` bits 5:0 and the read cycle time in bits 11:6. `done` is high for exactly one clock, on the first clock of the tick equal to the cycle time of the access type. `busy` is low from the next clock on.
- R7: A start while busy is ignored, and so are changes to the timing words, `rd_sel`, `cmd_sel` or `tick_x2` during an access. Neither changes the running access or the error flag.
- R8: A start with an invalid configuration sets `err`, which stays set until reset, and runs no access. A configuration is invalid if any of these fails: WE-off > WE-on, RE-off > RE-on, CS-off > CS-on, CS-off >= max(WE-off, RE-off), write cycle >= WE-off, read cycle >= RE-off, access time > RE-on, CS-off - CS-on >= the CS pulse width in `cyc_word` bits 17:12, and `cyc_word` bits 21:18 all zero.
- R9: After reset `busy`, `done`, `cap_o`, `err` and `rd_data` are zero and every strobe pin rests at its `pol_inv` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one access; taken only when idle |
| rd_sel | input | 1 | 1 = read access, 0 = write access |
| cmd_sel | input | 1 | 1 = drive A0 active during the access |
| tick_x2 | input | 1 | 1 = one tick lasts two clocks |
| pol_inv | input | 4 | Per-pin inversion: CS, WE, RE, A0 |
| edge_word | input | 30 | Packed strobe on/off tick positions |
| cyc_word | input | 28 | Packed cycle times, CS pulse width, access time |
| bus_din | input | DW | Bus data sampled on reads |
| cs_o | output | 1 | Chip-select pin |
| we_o | output | 1 | Write-enable pin |
| re_o | output | 1 | Read-enable pin |
| a0_o | output | 1 | Command/data pin |
| cap_o | output | 1 | One-clock read capture strobe |
| done | output | 1 | One-clock end-of-access pulse |
| busy | output | 1 | Access in progress |
| err | output | 1 | Sticky invalid-configuration flag |
| rd_data | output | DW | Last captured read data |

## Verification
The read capture and the end of the access land in the same clock when the access time equals the read cycle time. One read with doubled ticks sets both to tick 5, so the capture strobe and done both belong at clock 10 after start. The bench requires both at that clock. It also requires that the data captured there is the bus value present at the edge that ends the access, and that busy still drops on the following clock.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    localparam int ON_W    = 4;
    localparam int OFF_W   = 6;
    localparam int ONOFF_W = 3 * (ON_W + OFF_W);
    localparam int CYC_W   = 28;
    localparam int NSTRB   = 3;
    localparam int NPIN    = NSTRB + 1;
    localparam int S_CS    = 0;
    localparam int S_WE    = 1;
    localparam int S_RE    = 2;
    localparam int S_A0    = 3;

    typedef logic [OFF_W-1:0] tick_t;
    typedef logic [ON_W-1:0]  ontk_t;

    typedef struct packed {
        ontk_t cs_on;
        tick_t cs_off;
        ontk_t we_on;
        tick_t we_off;
        ontk_t re_on;
        tick_t re_off;
        tick_t wr_cyc;
        tick_t rd_cyc;
        tick_t acc;
    } tim_t;

    function automatic tim_t unpack_tim(input logic [ONOFF_W-1:0] w0,
                                        input logic [CYC_W-1:0]   w1);
        tim_t t;
        t.cs_on  = w0[3:0];
        t.cs_off = w0[9:4];
        t.we_on  = w0[13:10];
        t.we_off = w0[19:14];
        t.re_on  = w0[23:20];
        t.re_off = w0[29:24];
        t.wr_cyc = w1[5:0];
        t.rd_cyc = w1[11:6];
        t.acc    = w1[27:22];
        return t;
    endfunction

    function automatic logic tim_ok(input tim_t t, input logic [CYC_W-1:0] w1);
        tick_t cson, weon, reon, late, pw;
        cson = tick_t'(t.cs_on);
        weon = tick_t'(t.we_on);
        reon = tick_t'(t.re_on);
        late = (t.we_off > t.re_off) ? t.we_off : t.re_off;
        pw   = w1[17:12];
        return (t.we_off > weon) && (t.re_off > reon) && (t.cs_off > cson)
            && (t.cs_off >= late) && (t.wr_cyc >= t.we_off)
            && (t.rd_cyc >= t.re_off) && (t.acc > reon)
            && ((t.cs_off - cson) >= pw) && (w1[21:18] == 4'd0);
    endfunction
endpackage

// File: rtl/pbus_tick_gen.sv
module pbus_tick_gen #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic          run_i,
    input  logic          x2_i,
    output logic [TW-1:0] tick_o,
    output logic          first_o
);
    logic half_q;

    always_ff @(posedge clk) begin
        if (rst || load_i) begin
            tick_o <= '0;
            half_q <= 1'b0;
        end else if (run_i) begin
            if (x2_i && !half_q) begin
                half_q <= 1'b1;
            end else begin
                half_q <= 1'b0;
                tick_o <= tick_o + 1'b1;
            end
        end
    end

    assign first_o = !half_q;
endmodule

// File: rtl/pbus_strobe_win.sv
module pbus_strobe_win #(
    parameter int N  = 3,
    parameter int TW = 6
) (
    input  logic [TW-1:0]         tick_i,
    input  logic [N-1:0][TW-1:0]  on_i,
    input  logic [N-1:0][TW-1:0]  off_i,
    input  logic [N-1:0]          en_i,
    output logic [N-1:0]          act_o
);
    for (genvar i = 0; i < N; i++) begin : g_win
        assign act_o[i] = en_i[i] && (tick_i >= on_i[i]) && (tick_i < off_i[i]);
    end
endmodule

// File: rtl/pbus_strobe_timer.sv
module pbus_strobe_timer import pbus_pkg::*; #(
    parameter int DW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               rd_sel,
    input  logic               cmd_sel,
    input  logic               tick_x2,
    input  logic [NPIN-1:0]    pol_inv,
    input  logic [ONOFF_W-1:0] edge_word,
    input  logic [CYC_W-1:0]   cyc_word,
    input  logic [DW-1:0]      bus_din,
    output logic               cs_o,
    output logic               we_o,
    output logic               re_o,
    output logic               a0_o,
    output logic               cap_o,
    output logic               done,
    output logic               busy,
    output logic               err,
    output logic [DW-1:0]      rd_data
);
    tim_t    cfg_in, tim_q;
    logic    cfg_ok, accept, launch;
    logic    busy_q, rd_q, cmd_q, x2_q, err_q;
    logic [DW-1:0] rdat_q;
    tick_t   tick, cyc_sel;
    logic    first;
    logic    done_w, cap_w;

    logic [NSTRB-1:0][OFF_W-1:0] on_v, off_v;
    logic [NSTRB-1:0]            en_v, act_v;

    assign cfg_in = unpack_tim(edge_word, cyc_word);
    assign cfg_ok = tim_ok(cfg_in, cyc_word);
    assign accept = start && !busy_q;
    assign launch = accept && cfg_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            rd_q   <= 1'b0;
            cmd_q  <= 1'b0;
            x2_q   <= 1'b0;
            err_q  <= 1'b0;
            tim_q  <= '0;
            rdat_q <= '0;
        end else begin
            if (launch) begin
                busy_q <= 1'b1;
                tim_q  <= cfg_in;
                rd_q   <= rd_sel;
                cmd_q  <= cmd_sel;
                x2_q   <= tick_x2;
            end else if (done_w) begin
                busy_q <= 1'b0;
            end
            if (accept && !cfg_ok) begin
                err_q <= 1'b1;
            end
            if (cap_w) begin
                rdat_q <= bus_din;
            end
        end
    end

    pbus_tick_gen #(.TW(OFF_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .load_i  (launch),
        .run_i   (busy_q),
        .x2_i    (x2_q),
        .tick_o  (tick),
        .first_o (first)
    );

    assign cyc_sel = rd_q ? tim_q.rd_cyc : tim_q.wr_cyc;
    assign done_w  = busy_q && first && (tick == cyc_sel);
    assign cap_w   = busy_q && rd_q && first && (tick == tim_q.acc);

    assign on_v[S_CS]  = tick_t'(tim_q.cs_on);
    assign on_v[S_WE]  = tick_t'(tim_q.we_on);
    assign on_v[S_RE]  = tick_t'(tim_q.re_on);
    assign off_v[S_CS] = tim_q.cs_off;
    assign off_v[S_WE] = tim_q.we_off;
    assign off_v[S_RE] = tim_q.re_off;
    assign en_v[S_CS]  = busy_q;
    assign en_v[S_WE]  = busy_q && !rd_q;
    assign en_v[S_RE]  = busy_q && rd_q;

    pbus_strobe_win #(.N(NSTRB), .TW(OFF_W)) u_win (
        .tick_i (tick),
        .on_i   (on_v),
        .off_i  (off_v),
        .en_i   (en_v),
        .act_o  (act_v)
    );

    assign cs_o    = act_v[S_CS] ^ pol_inv[S_CS];
    assign we_o    = act_v[S_WE] ^ pol_inv[S_WE];
    assign re_o    = act_v[S_RE] ^ pol_inv[S_RE];
    assign a0_o    = (busy_q && cmd_q) ^ pol_inv[S_A0];
    assign cap_o   = cap_w;
    assign done    = done_w;
    assign busy    = busy_q;
    assign err     = err_q;
    assign rd_data = rdat_q;
endmodule

// File: rtl/pbus_strobe_chk.sv
module pbus_strobe_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       cap_o,
    input logic       cs_o,
    input logic       we_o,
    input logic       re_o,
    input logic [3:0] pol_inv
);
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_drop_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    p_cs_in_busy_r1: assert property (@(posedge clk) disable iff (rst)
        (cs_o != pol_inv[0]) |-> busy);

    p_we_re_excl_r1: assert property (@(posedge clk) disable iff (rst)
        !((we_o != pol_inv[1]) && (re_o != pol_inv[2])));

    p_cap_read_r5: assert property (@(posedge clk) disable iff (rst)
        cap_o |-> (busy && (we_o == pol_inv[1])));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    p_err_no_run_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> !busy);
endmodule

bind pbus_strobe_timer pbus_strobe_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .cap_o   (cap_o),
    .cs_o    (cs_o),
    .we_o    (we_o),
    .re_o    (re_o),
    .pol_inv (pol_inv)
);

// File: tb/pbus_strobe_timer_test.sv
module pbus_strobe_timer_test;
    localparam int DW = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst, start, rd_sel, cmd_sel, tick_x2;
    logic [3:0]    pol_inv;
    logic [29:0]   edge_word;
    logic [27:0]   cyc_word;
    logic [DW-1:0] bus_din;
    logic          cs_o, we_o, re_o, a0_o, cap_o, done, busy, err;
    logic [DW-1:0] rd_data;

    pbus_strobe_timer #(.DW(DW)) uut (
        .clk(clk), .rst(rst), .start(start), .rd_sel(rd_sel), .cmd_sel(cmd_sel),
        .tick_x2(tick_x2), .pol_inv(pol_inv), .edge_word(edge_word),
        .cyc_word(cyc_word), .bus_din(bus_din), .cs_o(cs_o), .we_o(we_o),
        .re_o(re_o), .a0_o(a0_o), .cap_o(cap_o), .done(done), .busy(busy),
        .err(err), .rd_data(rd_data)
    );

    typedef struct {
        int    cs_f, cs_n, we_f, we_n, re_f, re_n, a0_n, done_i, cap_i;
        bit    rd;
        string grp;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [29:0] mk_edge(input int cson, csoff, weon, weoff, reon, reoff);
        return {6'(reoff), 4'(reon), 6'(weoff), 4'(weon), 6'(csoff), 4'(cson)};
    endfunction

    function automatic logic [27:0] mk_cyc(input int wc, rc, pw, acc);
        return {6'(acc), 4'b0000, 6'(pw), 6'(rc), 6'(wc)};
    endfunction

    // scoreboard monitor
    int      m_act = 0;
    int      idx, cs_f, cs_n, we_f, we_n, re_f, re_n, a0_n, done_i, done_n, cap_i, late_busy;
    int      cap_pend;
    logic [DW-1:0] cap_val;
    logic [15:0]   pat = 16'h1234;
    exp_t    e;

    initial begin
        bus_din = '0;
        forever begin
            @(negedge clk);
            if (m_act == 0 && q.size() > 0) begin
                m_act = 1; idx = 0;
                cs_f = -1; cs_n = 0; we_f = -1; we_n = 0; re_f = -1; re_n = 0;
                a0_n = 0; done_i = -1; done_n = 0; cap_i = -1; late_busy = 0; cap_pend = 0;
                e = q[0];
            end
            if (m_act != 0) begin
                if (cs_o != pol_inv[0]) begin if (cs_f < 0) cs_f = idx; cs_n++; end
                if (we_o != pol_inv[1]) begin if (we_f < 0) we_f = idx; we_n++; end
                if (re_o != pol_inv[2]) begin if (re_f < 0) re_f = idx; re_n++; end
                if (a0_o != pol_inv[3]) a0_n++;
                if (done) begin done_n++; if (done_i < 0) done_i = idx; end
                if (cap_o) begin cap_i = idx; cap_pend = 1; end
                if (done_i >= 0 && idx == done_i + 1 && e.rd)
                    chk({e.grp, " R5 rd_data"}, int'(rd_data), int'(cap_val));
                if (done_i >= 0 && idx > done_i && busy) late_busy++;
                if ((done_i >= 0 && idx == done_i + 4) || idx > 400) begin
                    chk({e.grp, " R1 cs first"}, cs_f, e.cs_f);
                    chk({e.grp, " R1 cs width"}, cs_n, e.cs_n);
                    chk({e.grp, " R1 we width"}, we_n, e.we_n);
                    if (e.we_n > 0) chk({e.grp, " R1 we first"}, we_f, e.we_f);
                    chk({e.grp, " R1 re width"}, re_n, e.re_n);
                    if (e.re_n > 0) chk({e.grp, " R1 re first"}, re_f, e.re_f);
                    chk({e.grp, " R4 a0 span"}, a0_n, e.a0_n);
                    chk({e.grp, " R6 done pos"}, done_i, e.done_i);
                    chk({e.grp, " R6 done once"}, done_n, 1);
                    chk({e.grp, " R6 busy after done"}, late_busy, 0);
                    chk({e.grp, " R5 capture pos"}, cap_i, e.cap_i);
                    void'(q.pop_front());
                    m_act = 0;
                end
                idx++;
            end
            pat = pat * 16'd25173 + 16'd13849;
            bus_din = pat;
            if (cap_pend != 0) begin cap_val = bus_din; cap_pend = 0; end
        end
    end

    task automatic run_access(input int cson, csoff, weon, weoff, reon, reoff,
                              input int wc, rc, acc, input bit rd, cmd, x2,
                              input logic [3:0] pol, input bit disturb, input string grp);
        exp_t x;
        int   s, cyc;
        logic err_before;
        s   = x2 ? 2 : 1;
        cyc = rd ? rc : wc;
        x.cs_f = cson * s;           x.cs_n = (csoff - cson) * s;
        x.we_f = rd ? -1 : weon * s; x.we_n = rd ? 0 : (weoff - weon) * s;
        x.re_f = rd ? reon * s : -1; x.re_n = rd ? (reoff - reon) * s : 0;
        x.a0_n = cmd ? cyc * s + 1 : 0;
        x.done_i = cyc * s;
        x.cap_i = (rd && acc <= rc) ? acc * s : -1;
        x.rd = rd;
        x.grp = grp;
        @(negedge clk);
        err_before = err;
        pol_inv = pol; rd_sel = rd; cmd_sel = cmd; tick_x2 = x2;
        edge_word = mk_edge(cson, csoff, weon, weoff, reon, reoff);
        cyc_word = mk_cyc(wc, rc, 0, acc);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        q.push_back(x);
        if (disturb) begin
            repeat (2) @(negedge clk);
            start = 1'b1;
            edge_word = ~edge_word; cyc_word = ~cyc_word;
            rd_sel = ~rd_sel; cmd_sel = ~cmd_sel; tick_x2 = ~tick_x2;
            @(negedge clk);
            start = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        chk({grp, " R7 err unchanged"}, int'(err), int'(err_before));
        chk({grp, " R3 idle cs"}, int'(cs_o), int'(pol[0]));
        chk({grp, " R3 idle we"}, int'(we_o), int'(pol[1]));
        chk({grp, " R3 idle re"}, int'(re_o), int'(pol[2]));
        chk({grp, " R3 idle a0"}, int'(a0_o), int'(pol[3]));
    endtask

    task automatic bad_access(input logic [29:0] ew, input logic [27:0] cw, input string tag);
        int seen;
        seen = 0;
        @(negedge clk);
        pol_inv = 4'b0000; rd_sel = 1'b0; cmd_sel = 1'b1; tick_x2 = 1'b0;
        edge_word = ew; cyc_word = cw; start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (busy || cs_o || we_o || a0_o || done) seen++;
        end
        chk({tag, " R8 err set"}, int'(err), 1);
        chk({tag, " R8 no access"}, seen, 0);
    endtask

    task automatic finish_up;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        rst = 1'b1; start = 1'b0; rd_sel = 1'b0; cmd_sel = 1'b0; tick_x2 = 1'b0;
        pol_inv = 4'b0000; edge_word = '0; cyc_word = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 busy", int'(busy), 0);
        chk("R9 done", int'(done), 0);
        chk("R9 cap", int'(cap_o), 0);
        chk("R9 err", int'(err), 0);
        chk("R9 rd_data", int'(rd_data), 0);
        chk("R9 pins", int'({cs_o, we_o, re_o, a0_o}), 0);

        run_access(1, 9, 2, 6, 3, 5, 10, 8, 4, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b0, "R1 write");
        run_access(0, 7, 1, 3, 2, 6, 4, 7, 5, 1'b1, 1'b0, 1'b0, 4'b1111, 1'b0, "R3 read lowpol");
        // capture and done fall on the same clock (tick 5, doubled)
        run_access(0, 5, 1, 2, 1, 5, 3, 5, 5, 1'b1, 1'b1, 1'b1, 4'b0000, 1'b0, "R2 read coincide");
        run_access(2, 6, 3, 5, 0, 1, 6, 2, 1, 1'b0, 1'b1, 1'b1, 4'b0101, 1'b1, "R7 write disturbed");
        run_access(15, 63, 15, 40, 14, 50, 63, 63, 62, 1'b1, 1'b1, 1'b0, 4'b1010, 1'b0, "R1 read maxfields");

        bad_access(mk_edge(1, 9, 5, 5, 3, 5), mk_cyc(10, 8, 0, 4), "R8 we order");
        bad_access(mk_edge(1, 4, 2, 3, 3, 5), mk_cyc(10, 8, 0, 4), "R8 cs late");
        bad_access(mk_edge(1, 9, 2, 6, 3, 5), mk_cyc(10, 8, 0, 3), "R8 access early");
        bad_access(mk_edge(1, 9, 2, 6, 3, 5), mk_cyc(10, 4, 0, 4), "R8 read cycle short");
        bad_access(mk_edge(1, 9, 2, 6, 3, 5), mk_cyc(10, 8, 9, 4), "R8 cs pulse");
        bad_access(mk_edge(1, 9, 2, 6, 3, 5), mk_cyc(10, 8, 0, 4) | 28'h0040000, "R8 reserved");

        run_access(1, 9, 2, 6, 3, 5, 10, 8, 4, 1'b1, 1'b0, 1'b0, 4'b0000, 1'b0, "R8 sticky read");
        chk("R8 err still set", int'(err), 1);

        finish_up();
    end
endmodule